// File: doc/BRIEF.md
# Debug halt control and status register

This block is a single 32-bit memory-mapped register that an external debugger uses to stop, single-step and restart a processor core. Writes go through a plain write strobe with write data. A write counts only when the upper halfword of the data carries a fixed unlock key, which keeps stray writes from disturbing the core. The low bits of the register hold the control state. This state drives three lines into the core: a halt request, a step request and an interrupt mask.

The upper bits report core status. Halted and sleeping follow the core's inputs directly. Lockup, register-transfer ready and three sticky event flags are held in the block. The sticky flags record a core reset, a retired instruction and a restart from halt. Each of them clears on the clock edge after a read unless the same event recurs in that cycle.

A single-step sequencer lets exactly one instruction retire after the halt is released and then halts the core again. A reset catch option raises the halt request as the core comes out of system reset, so the debugger gains control before the first instruction runs.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write takes effect only when write data bits 31:16 equal 0xA05F. Any other write changes no control bit.
- R2: The control bits read back at these positions: debug enable at bit 0, halt at bit 1, step at bit 2, interrupt mask at bit 3, snapshot stall at bit 5 and reset catch at bit 8. The outputs `halt_req`, `step_req` and `mask_irq` equal bits 1, 2 and 3.
- R3: The interrupt mask bit takes the written value only when halt was 1 before the keyed write and that write also sets halt to 1. In every other case the mask bit keeps its value.
- R4: While `por_n` is low, all control bits, sticky bits, lockup and ready clear to 0. While `sys_rst_n` is low, only halt and the step sequence clear; debug enable and the other control bits keep their values.
- R5: Bit 25 becomes 1 after a `core_reset_evt` cycle, and bit 24 becomes 1 after a `core_retired` cycle. Each one clears on the edge after a read cycle, but it stays 1 if its event happens in that same read cycle.
- R6: Bit 26 becomes 1 after a keyed write clears halt while halt was 1 and `core_halted` is high. It clears after a read.
- R7: Bit 16 clears after a `sel_wr` cycle and sets after a `core_xfer_done` cycle. When both arrive in the same cycle, the clear wins.
- R8: Bit 19 sets after `core_lockup` and holds until a cycle in which `core_halted` is high, which clears it. Bits 17 and 18 follow `core_halted` and `core_sleeping` in the same cycle.
- R9: A keyed write that clears halt while halt was 1 and sets step arms a single step. Halt stays low until the first `core_retired` cycle, and halt reads 1 on the edge after that cycle.
- R10: If reset catch and debug enable are both 1, halt becomes 1 on the first edge after `sys_rst_n` returns high. If either of them is 0, halt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears sticky bits) |
| reg_wdata | input | 32 | Write data, key in bits 31:16 |
| reg_rdata | output | 32 | Current register value |
| sel_wr | input | 1 | Core register selector was written |
| core_halted | input | 1 | Core is in halted state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core is locked up |
| core_reset_evt | input | 1 | Core reset occurred this cycle |
| core_retired | input | 1 | An instruction retired this cycle |
| core_xfer_done | input | 1 | Core register transfer finished |
| halt_req | output | 1 | Halt request to the core |
| step_req | output | 1 | Step request to the core |
| mask_irq | output | 1 | Interrupt mask to the core |

## Verification
The bench tries to change the mask bit on a write that releases halt, and on a write that follows a cycle with halt low. A design that checks only the new halt value would let the mask change while the core is running. It reads the register in the same cycle that a sticky event arrives; a design that gives the clear priority would lose that event. It stays in the stepping state for several idle cycles before the retire pulse, and a sequencer that counts cycles instead of retires would halt the core too early. It also asserts system reset with reset catch both armed and disarmed. This shows whether debug enable survives system reset and whether the halt comes back on release.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int REG_W    = 32;
  localparam int KEY_LSB  = 16;
  localparam int KEY_W    = REG_W - KEY_LSB;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA05F;
  localparam int NSTK     = 3;

  localparam int B_DBG    = 0;
  localparam int B_HALT   = 1;
  localparam int B_STEP   = 2;
  localparam int B_MASK   = 3;
  localparam int B_SNAP   = 5;
  localparam int B_CATCH  = 8;
  localparam int B_RDY    = 16;
  localparam int B_HLTD   = 17;
  localparam int B_SLEEP  = 18;
  localparam int B_LOCK   = 19;
  localparam int B_RETIRE = 24;
  localparam int B_RSTST  = 25;
  localparam int B_RESTRT = 26;

  localparam int STK_RETIRE = 0;
  localparam int STK_RESET  = 1;
  localparam int STK_RESTRT = 2;

  typedef struct packed {
    logic catch_rst;
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic dbg;
  } ctrl_t;

  typedef struct packed {
    logic       rdy;
    logic       halted;
    logic       sleep;
    logic       lock;
    logic [NSTK-1:0] stk;
  } stat_t;

  function automatic logic key_ok(input logic wr, input logic [KEY_W-1:0] upper);
    return wr && (upper == WR_KEY);
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input ctrl_t c, input stat_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_DBG]    = c.dbg;
    w[B_HALT]   = c.halt;
    w[B_STEP]   = c.step;
    w[B_MASK]   = c.mask;
    w[B_SNAP]   = c.snap;
    w[B_CATCH]  = c.catch_rst;
    w[B_RDY]    = s.rdy;
    w[B_HLTD]   = s.halted;
    w[B_SLEEP]  = s.sleep;
    w[B_LOCK]   = s.lock;
    w[B_RETIRE] = s.stk[STK_RETIRE];
    w[B_RSTST]  = s.stk[STK_RESET];
    w[B_RESTRT] = s.stk[STK_RESTRT];
    return w;
  endfunction
endpackage

// File: rtl/dhc_sticky.sv
module dhc_sticky (
  input  logic clk,
  input  logic por_n,
  input  logic rd_clr,
  input  logic set_evt,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!por_n) q <= 1'b0;
    else        q <= set_evt | (q & ~rd_clr);
  end

  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!por_n)
    (rd_clr && !set_evt) |=> !q);
  assert_event_kept_R5: assert property (@(posedge clk) disable iff (!por_n)
    set_evt |=> q);
endmodule

// File: rtl/dhc_status.sv
module dhc_status
  import dhc_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic rd_evt,
  input  logic release_evt,
  input  logic core_halted,
  input  logic core_lockup,
  input  logic core_reset_evt,
  input  logic core_retired,
  input  logic sel_wr,
  input  logic core_xfer_done,
  output logic rdy,
  output logic lock,
  output logic [NSTK-1:0] stk
);
  logic [NSTK-1:0] stk_set;
  logic restart_evt;

  assign restart_evt = release_evt & core_halted;
  assign stk_set[STK_RETIRE] = core_retired;
  assign stk_set[STK_RESET]  = core_reset_evt;
  assign stk_set[STK_RESTRT] = restart_evt;

  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    dhc_sticky u_stk (
      .clk    (clk),
      .por_n  (por_n),
      .rd_clr (rd_evt),
      .set_evt(stk_set[i]),
      .q      (stk[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      rdy  <= 1'b0;
      lock <= 1'b0;
    end else begin
      if (sel_wr)              rdy <= 1'b0;
      else if (core_xfer_done) rdy <= 1'b1;
      lock <= core_halted ? 1'b0 : (lock | core_lockup);
    end
  end

  assert_restart_set_R6: assert property (@(posedge clk) disable iff (!por_n)
    restart_evt |=> stk[STK_RESTRT]);
  assert_rdy_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    sel_wr |=> !rdy);
  assert_lock_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
    core_halted |=> !lock);
endmodule

// File: rtl/dhc_ctrl.sv
module dhc_ctrl
  import dhc_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  sys_rst_n,
  input  logic  wr_ok,
  input  ctrl_t wr_ctrl,
  input  logic  core_retired,
  output ctrl_t ctrl,
  output logic  release_evt
);
  logic dbg_q, step_q, mask_q, snap_q, catch_q;
  logic halt_q, stepping_q, catch_pend_q;
  logic mask_ok, catch_fire, rehalt;

  assign mask_ok     = wr_ok & halt_q & wr_ctrl.halt;
  assign release_evt = wr_ok & halt_q & ~wr_ctrl.halt;
  assign catch_fire  = catch_pend_q & catch_q & dbg_q;
  assign rehalt      = stepping_q & core_retired;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      dbg_q   <= 1'b0;
      step_q  <= 1'b0;
      mask_q  <= 1'b0;
      snap_q  <= 1'b0;
      catch_q <= 1'b0;
    end else if (wr_ok) begin
      dbg_q   <= wr_ctrl.dbg;
      step_q  <= wr_ctrl.step;
      snap_q  <= wr_ctrl.snap;
      catch_q <= wr_ctrl.catch_rst;
      if (mask_ok) mask_q <= wr_ctrl.mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !sys_rst_n) begin
      halt_q       <= 1'b0;
      stepping_q   <= 1'b0;
      catch_pend_q <= 1'b1;
    end else begin
      catch_pend_q <= 1'b0;
      if (catch_fire || rehalt) halt_q <= 1'b1;
      else if (wr_ok)           halt_q <= wr_ctrl.halt;
      if (rehalt)     stepping_q <= 1'b0;
      else if (wr_ok) stepping_q <= release_evt & wr_ctrl.step;
    end
  end

  assign ctrl = '{catch_rst: catch_q, snap: snap_q, mask: mask_q,
                  step: step_q, halt: halt_q, dbg: dbg_q};

  assert_keyless_ignored_R1: assert property (@(posedge clk) disable iff (!por_n)
    !wr_ok |=> ($stable(dbg_q) && $stable(catch_q) && $stable(step_q)));
  assert_mask_guard_R3: assert property (@(posedge clk) disable iff (!por_n)
    !mask_ok |=> $stable(mask_q));
  assert_sysrst_clears_halt_R4: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> !halt_q);
  assert_step_rehalt_R9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    rehalt |=> halt_q);
  assert_catch_halt_R10: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    catch_fire |=> halt_q);
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dhc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sel_wr,
  input  logic             core_halted,
  input  logic             core_sleeping,
  input  logic             core_lockup,
  input  logic             core_reset_evt,
  input  logic             core_retired,
  input  logic             core_xfer_done,
  output logic             halt_req,
  output logic             step_req,
  output logic             mask_irq
);
  logic  wr_ok;
  logic  release_evt;
  ctrl_t wr_ctrl;
  ctrl_t ctrl;
  stat_t stat;
  logic  rdy, lock;
  logic [NSTK-1:0] stk;
  logic  unused_wbits;

  assign wr_ok   = key_ok(reg_wr_en, reg_wdata[REG_W-1:KEY_LSB]);
  assign wr_ctrl = '{catch_rst: reg_wdata[B_CATCH], snap: reg_wdata[B_SNAP],
                     mask: reg_wdata[B_MASK], step: reg_wdata[B_STEP],
                     halt: reg_wdata[B_HALT], dbg: reg_wdata[B_DBG]};
  assign unused_wbits = ^{reg_wdata[KEY_LSB-1:B_CATCH+1], reg_wdata[B_CATCH-1:B_SNAP+1],
                          reg_wdata[B_SNAP-1:B_MASK+1]};

  dhc_ctrl u_ctrl (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .wr_ok       (wr_ok),
    .wr_ctrl     (wr_ctrl),
    .core_retired(core_retired),
    .ctrl        (ctrl),
    .release_evt (release_evt)
  );

  dhc_status u_status (
    .clk           (clk),
    .por_n         (por_n),
    .rd_evt        (reg_rd_en),
    .release_evt   (release_evt),
    .core_halted   (core_halted),
    .core_lockup   (core_lockup),
    .core_reset_evt(core_reset_evt),
    .core_retired  (core_retired),
    .sel_wr        (sel_wr),
    .core_xfer_done(core_xfer_done),
    .rdy           (rdy),
    .lock          (lock),
    .stk           (stk)
  );

  assign stat = '{rdy: rdy, halted: core_halted, sleep: core_sleeping, lock: lock, stk: stk};
  assign reg_rdata = pack_word(ctrl, stat);
  assign halt_req  = ctrl.halt;
  assign step_req  = ctrl.step;
  assign mask_irq  = ctrl.mask;

  assert_por_clears_R4: assert property (@(posedge clk)
    !por_n |=> (reg_rdata[B_DBG] == 1'b0 && reg_rdata[B_RSTST] == 1'b0));
  assert_lock_needs_event_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!core_lockup && !lock) |=> !lock);
endmodule

// File: tb/dbg_halt_ctl_bench.sv
module dbg_halt_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'hA05F;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sel_wr = 1'b0, core_halted = 1'b0, core_sleeping = 1'b0, core_lockup = 1'b0;
  logic core_reset_evt = 1'b0, core_retired = 1'b0, core_xfer_done = 1'b0;
  logic halt_req, step_req, mask_irq;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctl u_dbg_halt_ctl (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sel_wr(sel_wr), .core_halted(core_halted),
    .core_sleeping(core_sleeping), .core_lockup(core_lockup),
    .core_reset_evt(core_reset_evt), .core_retired(core_retired),
    .core_xfer_done(core_xfer_done), .halt_req(halt_req), .step_req(step_req),
    .mask_irq(mask_irq)
  );

  // behavioural reference state
  bit m_dbg, m_halt, m_step, m_mask, m_snap, m_catch;
  bit m_stepping, m_pend, m_rdy, m_lock, m_ret, m_rst, m_restart;

  always @(posedge clk) begin
    bit w, rel, fire, nh, ns;
    if (!por_n) begin
      {m_dbg, m_halt, m_step, m_mask, m_snap, m_catch} = '0;
      {m_stepping, m_rdy, m_lock, m_ret, m_rst, m_restart} = '0;
      m_pend = 1;
      started = 1;
    end else begin
      w    = reg_wr_en && (reg_wdata[31:16] == KEY);
      rel  = w && m_halt && !reg_wdata[1];
      fire = m_pend && m_catch && m_dbg;
      m_restart = (m_restart && !reg_rd_en) || (rel && core_halted);
      m_rst     = (m_rst && !reg_rd_en) || core_reset_evt;
      m_ret     = (m_ret && !reg_rd_en) || core_retired;
      if (sel_wr) m_rdy = 0; else if (core_xfer_done) m_rdy = 1;
      m_lock = core_halted ? 0 : (m_lock || core_lockup);
      nh = m_halt; ns = m_stepping;
      if (w) begin
        if (m_halt && reg_wdata[1]) m_mask = reg_wdata[3];
        m_dbg = reg_wdata[0]; m_step = reg_wdata[2];
        m_snap = reg_wdata[5]; m_catch = reg_wdata[8];
        nh = reg_wdata[1];
        ns = rel && reg_wdata[2];
      end
      if (m_stepping && core_retired) begin nh = 1; ns = 0; end
      if (fire) nh = 1;
      if (!sys_rst_n) begin nh = 0; ns = 0; m_pend = 1; end
      else m_pend = 0;
      m_halt = nh; m_stepping = ns;
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] v;
    v = 32'(m_dbg) + (32'(m_halt) << 1) + (32'(m_step) << 2) + (32'(m_mask) << 3)
      + (32'(m_snap) << 5) + (32'(m_catch) << 8) + (32'(m_rdy) << 16)
      + (32'(core_halted) << 17) + (32'(core_sleeping) << 18) + (32'(m_lock) << 19)
      + (32'(m_ret) << 24) + (32'(m_rst) << 25) + (32'(m_restart) << 26);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("R2 model rdata", reg_rdata, model_word());
      check("R2 model outputs", {29'd0, halt_req, step_req, mask_irq},
            {29'd0, 1'(m_halt), 1'(m_step), 1'(m_mask)});
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wdata = d; cyc();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd();
    reg_rd_en = 1'b1; cyc(); reg_rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #2;
    cyc(); cyc();
    por_n = 1'b1; sys_rst_n = 1'b1;
    cyc();
    check("R4 por state", reg_rdata, 32'h0);

    wr(32'h1234_0003);
    check("R1 bad key halt", {31'd0, halt_req}, 32'd0);
    check("R1 bad key word", reg_rdata, 32'h0);

    wr({KEY, 16'h0003});
    check("R2 halt out", {31'd0, halt_req}, 32'd1);
    check("R2 word", reg_rdata, 32'h3);

    wr({KEY, 16'h000B});
    check("R3 mask set while halted", {31'd0, mask_irq}, 32'd1);
    wr({KEY, 16'h0001});
    check("R3 mask kept on release", {31'd0, mask_irq}, 32'd1);
    check("R3 halt released", {31'd0, halt_req}, 32'd0);
    wr({KEY, 16'h0003});
    check("R3 mask kept from running", {31'd0, mask_irq}, 32'd1);
    wr({KEY, 16'h0003});
    check("R3 mask cleared while halted", {31'd0, mask_irq}, 32'd0);

    core_halted = 1'b1;
    wr({KEY, 16'h0001});
    check("R6 restart set", {31'd0, reg_rdata[26]}, 32'd1);
    check("R8 halted mirror", {31'd0, reg_rdata[17]}, 32'd1);
    rd();
    check("R6 restart cleared", {31'd0, reg_rdata[26]}, 32'd0);

    core_reset_evt = 1'b1; cyc(); core_reset_evt = 1'b0;
    check("R5 reset sticky set", {31'd0, reg_rdata[25]}, 32'd1);
    core_reset_evt = 1'b1; reg_rd_en = 1'b1; cyc();
    core_reset_evt = 1'b0; reg_rd_en = 1'b0;
    check("R5 event beats read", {31'd0, reg_rdata[25]}, 32'd1);
    rd();
    check("R5 reset sticky cleared", {31'd0, reg_rdata[25]}, 32'd0);

    core_xfer_done = 1'b1; cyc(); core_xfer_done = 1'b0;
    check("R7 ready set", {31'd0, reg_rdata[16]}, 32'd1);
    sel_wr = 1'b1; core_xfer_done = 1'b1; cyc();
    sel_wr = 1'b0; core_xfer_done = 1'b0;
    check("R7 select clear wins", {31'd0, reg_rdata[16]}, 32'd0);

    core_halted = 1'b0;
    core_lockup = 1'b1; cyc(); core_lockup = 1'b0;
    cyc(); cyc();
    check("R8 lockup held", {31'd0, reg_rdata[19]}, 32'd1);
    core_sleeping = 1'b1; #1;
    check("R8 sleep mirror", {31'd0, reg_rdata[18]}, 32'd1);
    core_sleeping = 1'b0;
    core_halted = 1'b1; cyc();
    check("R8 lockup cleared by halt", {31'd0, reg_rdata[19]}, 32'd0);

    wr({KEY, 16'h0003});
    wr({KEY, 16'h0005});
    check("R9 halt released for step", {31'd0, halt_req}, 32'd0);
    check("R2 step out", {31'd0, step_req}, 32'd1);
    cyc(); cyc(); cyc();
    check("R9 no rehalt without retire", {31'd0, halt_req}, 32'd0);
    core_retired = 1'b1; cyc(); core_retired = 1'b0;
    check("R9 rehalt after retire", {31'd0, halt_req}, 32'd1);
    check("R5 retired sticky", {31'd0, reg_rdata[24]}, 32'd1);
    cyc();
    check("R9 halt held", {31'd0, halt_req}, 32'd1);

    wr({KEY, 16'h0101});
    sys_rst_n = 1'b0; cyc(); cyc();
    check("R4 sysrst halt low", {31'd0, halt_req}, 32'd0);
    check("R4 sysrst keeps enable", {31'd0, reg_rdata[0]}, 32'd1);
    sys_rst_n = 1'b1; cyc();
    check("R10 catch halts", {31'd0, halt_req}, 32'd1);

    wr({KEY, 16'h0001});
    sys_rst_n = 1'b0; cyc(); cyc(); sys_rst_n = 1'b1; cyc();
    check("R10 no catch when disarmed", {31'd0, halt_req}, 32'd0);
    wr({KEY, 16'h0100});
    sys_rst_n = 1'b0; cyc(); cyc(); sys_rst_n = 1'b1; cyc();
    check("R10 no catch without enable", {31'd0, halt_req}, 32'd0);

    cyc(); cyc();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule